// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 8-bit processor built around a single accumulator. It uses 5-bit addresses, and code and data share one 32-byte memory. The memory sits inside the block as a synchronous RAM with one cycle of read latency. A test environment fills it before reset is released. Every clock performs exactly one register transfer among the program counter, the memory address register, the memory data register, the instruction register and the accumulator. As a result, each instruction takes a fixed number of cycles that depends only on its class.

An instruction word is one byte: a 3-bit operation code followed by a 5-bit operand address. The set has eight instructions: stop, load, store, add, subtract, jump, jump-if-zero and jump-if-positive. After a stop the core freezes and raises a status flag until the next reset. The program counter and the accumulator are brought out for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the program counter, the accumulator and `halted` become 0. The first cycle after release starts fetching the instruction at address 0.
- R2: An instruction byte holds the operation code in bits [7:5] and the operand address in bits [4:0]. The codes are 000 stop, 001 load, 010 store, 011 add, 100 subtract, 101 jump, 110 jump-if-zero and 111 jump-if-positive.
- R3: Every instruction begins with 5 cycles: address from the PC, a RAM wait, data register capture, instruction register capture and decode. None of these changes the PC, the accumulator or `halted`.
- R4: Load sets the accumulator to the memory byte at the operand address at the end of cycle 9. The PC advances by one at the end of cycle 10.
- R5: Add and subtract replace the accumulator with the sum or the difference (accumulator minus operand), wrapped modulo 256. They follow the same timing as load.
- R6: Store writes the accumulator to the operand address. The instruction takes 9 cycles, and the PC advances at the end of cycle 9.
- R7: Jump loads the operand address into the PC at the end of cycle 6.
- R8: Jump-if-zero is taken only when the accumulator is 0. Jump-if-positive is taken only when bit 7 is 0 and the value is nonzero. A jump that is not taken advances the PC by one. Both take 6 cycles.
- R9: Stop raises `halted` at the end of its cycle 5. The PC is not advanced, and the PC, the accumulator and memory then stay unchanged until reset.
- R10: The PC advances from 31 to 0.
- R11: A reset applied in the middle of an instruction restores the R1 state.
- R12: A program that loads +5, adds -3 (stored as 11111101) and stores the result must leave 2 at the target address and then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| halted | output | 1 | High once a stop instruction has executed |
| dbg_pc | output | 5 | Current program counter |
| dbg_acc | output | 8 | Current accumulator |

## Verification
A behavioural model predicts the PC, the accumulator and `halted` for every clock. It is run over four programs, and each one isolates different behaviour. The add-then-store program checks signed wrap-around and, through a second program that reads the result back, the memory write. A countdown loop with conditional jumps exercises subtract, taken and untaken branches on negative, zero and positive accumulators, and subtraction that wraps to 0xFF. A program placed at both ends of memory checks PC wrap-around, and a reset in the middle of an instruction checks recovery.

// File: rtl/acc_cpu_pkg.sv
// Package acc_cpu_pkg
// Shared encodings for the accumulator core: operation codes, controller
// states, accumulator operations and the control word that the controller
// sends to the datapath. Assumes a 3-bit operation code.
package acc_cpu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HLT = 3'b000,
        OP_LDA = 3'b001,
        OP_STA = 3'b010,
        OP_ADD = 3'b011,
        OP_SUB = 3'b100,
        OP_BR  = 3'b101,
        OP_BRZ = 3'b110,
        OP_BRP = 3'b111
    } opcode_t;

    typedef enum logic [3:0] {
        S_F_MAR,
        S_F_WAIT,
        S_F_MDR,
        S_F_IR,
        S_DECODE,
        S_O_MAR,
        S_O_WAIT,
        S_O_MDR,
        S_ALU,
        S_ST_MDR,
        S_ST_MAR,
        S_ST_WR,
        S_BRANCH,
        S_PC_INC,
        S_HALT
    } state_t;

    typedef enum logic [1:0] {
        ACC_HOLD,
        ACC_LOAD,
        ACC_ADD,
        ACC_SUB
    } acc_op_t;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_ir;
        logic    mdr_from_mem;
        logic    mdr_from_acc;
        logic    ir_ld;
        acc_op_t acc_op;
        logic    pc_inc;
        logic    pc_jump;
        logic    mem_we;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
// Module acc_cpu_mem
// Single-port synchronous RAM shared by code and data. A read returns the
// addressed word one cycle after the address is presented; a write takes
// effect at the clock edge. Contents are not reset; the environment
// preloads them.
module acc_cpu_mem #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write on request and register the read word every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
        rdata <= mem_q[addr];
    end

endmodule

// File: rtl/acc_cpu_alu.sv
// Module acc_cpu_alu
// Combinational next-accumulator selection: hold, load from the data
// register, add or subtract. Arithmetic wraps at the data width. Also
// reports zero and sign of the current accumulator for branch decisions.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  acc_op_t           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              acc_zero,
    output logic              acc_neg
);

    // Pick the value the accumulator takes on the next edge.
    always_comb begin
        unique case (op)
            ACC_LOAD: result = operand;
            ACC_ADD:  result = acc + operand;
            ACC_SUB:  result = acc - operand;
            default:  result = acc;
        endcase
    end

    // Flags for conditional jumps.
    always_comb begin
        acc_zero = (acc == '0);
        acc_neg  = acc[DATA_W-1];
    end

endmodule

// File: rtl/acc_cpu_datapath.sv
// Module acc_cpu_datapath
// Holds PC, MAR, MDR, IR and the accumulator and performs one transfer per
// control word. Assumes the instruction byte is opcode above address, so
// DATA_W equals OP_W + ADDR_W. Reset is synchronous and active low.
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output opcode_t           ir_op,
    output logic              acc_zero,
    output logic              acc_neg,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] acc
);
    localparam int OPC_LSB = DATA_W - OP_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_next;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr = ir_q[ADDR_W-1:0];
    assign ir_op   = opcode_t'(ir_q[DATA_W-1:OPC_LSB]);

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (ctrl.acc_op),
        .acc      (acc_q),
        .operand  (mdr_q),
        .result   (acc_next),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg)
    );

    // Program counter: step by one (wrapping) or load the jump target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctrl.pc_jump) begin
            pc_q <= ir_addr;
        end else if (ctrl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Memory address register: from PC for fetch, from IR for operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctrl.mar_from_pc) begin
            mar_q <= pc_q;
        end else if (ctrl.mar_from_ir) begin
            mar_q <= ir_addr;
        end
    end

    // Memory data register: capture the RAM word or the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (ctrl.mdr_from_mem) begin
            mdr_q <= mem_rdata;
        end else if (ctrl.mdr_from_acc) begin
            mdr_q <= acc_q;
        end
    end

    // Instruction register: copy of the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctrl.ir_ld) begin
            ir_q <= mdr_q;
        end
    end

    // Accumulator: takes the ALU result every cycle (hold when idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign pc        = pc_q;
    assign acc       = acc_q;

    // R5: a subtract leaves the old accumulator minus the data register.
    a_r5_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.acc_op == ACC_SUB |=> acc_q == $past(acc_q) - $past(mdr_q));

    // R4: a load puts the captured memory word in the accumulator.
    a_r4_load_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.acc_op == ACC_LOAD |=> acc_q == $past(mdr_q));

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module acc_cpu_ctrl
// Multicycle sequencer. Walks fetch (PC to MAR, RAM wait, MDR, IR),
// decode, then the per-class execute steps, issuing one transfer per
// cycle. Assumes RAM read latency of exactly one cycle. Holds the halted
// flag, which only reset clears.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_t ir_op,
    input  logic    acc_zero,
    input  logic    acc_neg,
    output ctrl_t   ctrl,
    output logic    halted
);
    state_t state_q;
    state_t state_d;
    logic   halt_set;
    logic   take_jump;

    // Jump decision for the three jump codes.
    always_comb begin
        unique case (ir_op)
            OP_BR:   take_jump = 1'b1;
            OP_BRZ:  take_jump = acc_zero;
            OP_BRP:  take_jump = !acc_neg && !acc_zero;
            default: take_jump = 1'b0;
        endcase
    end

    // Next state and control word for the current step.
    always_comb begin
        ctrl     = '0;
        halt_set = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            S_F_MAR: begin
                ctrl.mar_from_pc = 1'b1;
                state_d = S_F_WAIT;
            end
            S_F_WAIT: state_d = S_F_MDR;
            S_F_MDR: begin
                ctrl.mdr_from_mem = 1'b1;
                state_d = S_F_IR;
            end
            S_F_IR: begin
                ctrl.ir_ld = 1'b1;
                state_d = S_DECODE;
            end
            S_DECODE: begin
                unique case (ir_op)
                    OP_HLT: begin
                        halt_set = 1'b1;
                        state_d  = S_HALT;
                    end
                    OP_LDA, OP_ADD, OP_SUB: state_d = S_O_MAR;
                    OP_STA:                 state_d = S_ST_MDR;
                    default:                state_d = S_BRANCH;
                endcase
            end
            S_O_MAR: begin
                ctrl.mar_from_ir = 1'b1;
                state_d = S_O_WAIT;
            end
            S_O_WAIT: state_d = S_O_MDR;
            S_O_MDR: begin
                ctrl.mdr_from_mem = 1'b1;
                state_d = S_ALU;
            end
            S_ALU: begin
                unique case (ir_op)
                    OP_LDA:  ctrl.acc_op = ACC_LOAD;
                    OP_ADD:  ctrl.acc_op = ACC_ADD;
                    OP_SUB:  ctrl.acc_op = ACC_SUB;
                    default: ctrl.acc_op = ACC_HOLD;
                endcase
                state_d = S_PC_INC;
            end
            S_ST_MDR: begin
                ctrl.mdr_from_acc = 1'b1;
                state_d = S_ST_MAR;
            end
            S_ST_MAR: begin
                ctrl.mar_from_ir = 1'b1;
                state_d = S_ST_WR;
            end
            S_ST_WR: begin
                ctrl.mem_we = 1'b1;
                state_d = S_PC_INC;
            end
            S_BRANCH: begin
                ctrl.pc_jump = take_jump;
                ctrl.pc_inc  = !take_jump;
                state_d = S_F_MAR;
            end
            S_PC_INC: begin
                ctrl.pc_inc = 1'b1;
                state_d = S_F_MAR;
            end
            default: state_d = S_HALT;
        endcase
    end

    // State register, restarting at fetch on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_F_MAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Halted flag: set by a decoded stop, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (halt_set) begin
            halted <= 1'b1;
        end
    end

    // R3: fetch proceeds through its steps in order.
    a_r3_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_F_MAR |=> state_q == S_F_WAIT);

    // R8: a jump step always returns to fetch.
    a_r8_branch_returns: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_BRANCH |=> state_q == S_F_MAR);

endmodule

// File: rtl/acc_cpu_core.sv
// Module acc_cpu_core
// Top of the accumulator processor: sequencer, datapath and the shared
// code/data RAM. Exposes the halted flag and the PC and accumulator for
// observation. Assumes the RAM is preloaded before reset is released.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              halted,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_acc
);
    ctrl_t             ctrl;
    opcode_t           ir_op;
    logic              acc_zero;
    logic              acc_neg;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_op    (ir_op),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ctrl     (ctrl),
        .halted   (halted)
    );

    acc_cpu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ir_op     (ir_op),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg),
        .pc        (dbg_pc),
        .acc       (dbg_acc)
    );

    acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .addr  (mem_addr),
        .we    (ctrl.mem_we),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R1: reset clears PC, accumulator and halted.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> dbg_pc == '0 && dbg_acc == '0 && !halted);

    // R9: once halted, nothing observable changes.
    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(dbg_pc) && $stable(dbg_acc));

    // R6: the written word is the accumulator value.
    a_r6_write_data: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mem_we |-> mem_wdata == dbg_acc);

    // R10: a step moves the PC by one, wrapping at the top.
    a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_inc |=> dbg_pc == $past(dbg_pc) + 1'b1);

endmodule

// File: tb/acc_cpu_core_bench.sv
`timescale 1ns/1ps
// Bench for acc_cpu_core: a behavioural instruction model predicts
// PC, accumulator and halted for every clock and compares them.
module acc_cpu_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halted;
    logic [4:0] dbg_pc;
    logic [7:0] dbg_acc;

    int checks = 0;
    int errors = 0;
    int mmem [32];
    int m_pc, m_acc;
    bit m_halt;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_cpu_core u_acc_cpu_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted  (halted),
        .dbg_pc  (dbg_pc),
        .dbg_acc (dbg_acc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        u_acc_cpu_core.u_mem.mem_q[a] = v[7:0];
        mmem[a] = v & 255;
    endtask

    // Assert reset for two edges and check the R1 state at the ports.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dbg_pc == 0, "R1 pc", dbg_pc, 0);
        chk(dbg_acc == 0, "R1 acc", dbg_acc, 0);
        chk(halted == 0, "R1 halted", halted, 0);
        m_pc = 0; m_acc = 0; m_halt = 0;
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    // Run the model instruction by instruction, comparing every cycle.
    task automatic run_prog(input int max_instr);
        for (int n = 0; n < max_instr && !m_halt; n++) begin
            int ir, op, ad, len, acc_at, nacc, npc;
            string tg;
            ir = mmem[m_pc]; op = ir >> 5; ad = ir & 31;   // R2 field layout
            nacc = m_acc; npc = (m_pc + 1) % 32;           // R10 wrap
            acc_at = 99;
            case (op)
                0: begin len = 5; npc = m_pc; tg = "R9"; end
                1: begin len = 10; acc_at = 9; nacc = mmem[ad]; tg = "R4"; end
                2: begin len = 9; tg = "R6"; end
                3: begin len = 10; acc_at = 9; nacc = (m_acc + mmem[ad]) & 255; tg = "R5"; end
                4: begin len = 10; acc_at = 9; nacc = (m_acc - mmem[ad]) & 255; tg = "R5"; end
                5: begin len = 6; npc = ad; tg = "R7"; end
                6: begin len = 6; if (m_acc == 0) npc = ad; tg = "R8"; end
                default: begin len = 6; if (m_acc != 0 && m_acc < 128) npc = ad; tg = "R8"; end
            endcase
            for (int k = 1; k <= len; k++) begin
                int e_acc, e_pc, e_h;
                @(posedge clk);
                @(negedge clk);
                e_acc = (k >= acc_at) ? nacc : m_acc;
                e_pc  = (k >= len) ? npc : m_pc;
                e_h   = (op == 0 && k >= 5) ? 1 : 0;
                if (k <= 4) tg = (op == 0) ? "R9" : tg;
                chk(dbg_acc == e_acc, {tg, " acc"}, dbg_acc, e_acc);
                chk(dbg_pc == e_pc, {tg, " pc"}, dbg_pc, e_pc);
                chk(halted == e_h, {tg, " halted"}, halted, e_h);
                if (k == 4 && op != 0)
                    chk(dbg_pc == m_pc && halted == 0, "R3 fetch quiet", dbg_pc, m_pc);
            end
            chk(dbg_pc == npc, "R2 decode", dbg_pc, npc);
            if (op == 2) mmem[ad] = m_acc;
            m_acc = nacc; m_pc = npc;
            if (op == 0) m_halt = 1;
        end
        // R9: frozen after stop
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(halted == 1 && dbg_pc == m_pc && dbg_acc == m_acc, "R9 frozen",
                {halted, dbg_pc, dbg_acc}, {1'b1, m_pc[4:0], m_acc[7:0]});
        end
    endtask

    initial begin
        for (int a = 0; a < 32; a++) begin
            u_acc_cpu_core.u_mem.mem_q[a] = 8'h00;
            mmem[a] = 0;
        end
        // Program 1 (R12): load +5, add -3, store to 10, stop.
        do_reset();
        poke(0, 8'h28); poke(1, 8'h69); poke(2, 8'h4A); poke(3, 8'h00);
        poke(8, 8'h05); poke(9, 8'hFD);
        release_reset();
        run_prog(10);
        chk(dbg_acc == 2, "R12 result", dbg_acc, 2);

        // Readback of address 10 through a load (R6, R12).
        do_reset();
        poke(0, 8'h2A); poke(1, 8'h00);
        release_reset();
        run_prog(5);
        chk(dbg_acc == 2, "R6 R12 stored value", dbg_acc, 2);

        // Program 2: countdown loop and conditional jumps (R5, R7, R8).
        do_reset();
        poke(0, 8'h34); poke(1, 8'h95); poke(2, 8'h54); poke(3, 8'hC5);
        poke(4, 8'hA1); poke(5, 8'h36); poke(6, 8'hE9); poke(7, 8'hC9);
        poke(8, 8'h35); poke(9, 8'hEB); poke(10, 8'h00); poke(11, 8'h95);
        poke(12, 8'hEE); poke(13, 8'h95); poke(14, 8'h58); poke(15, 8'h00);
        poke(20, 3); poke(21, 1); poke(22, 8'h80);
        release_reset();
        run_prog(40);
        chk(dbg_acc == 255, "R5 wrap to 0xFF", dbg_acc, 255);
        chk(dbg_pc == 15, "R8 path end", dbg_pc, 15);

        // Program 3: PC wrap from 31 to 0 (R10).
        do_reset();
        poke(0, 8'hDF); poke(1, 8'h00); poke(30, 7); poke(31, 8'h3E);
        release_reset();
        run_prog(6);
        chk(dbg_pc == 1 && dbg_acc == 7, "R10 wrap", dbg_pc, 1);

        // Reset in the middle of an instruction (R11).
        do_reset();
        release_reset();
        repeat (13) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dbg_pc == 0, "R11 pc", dbg_pc, 0);
        chk(dbg_acc == 0, "R11 acc", dbg_acc, 0);
        chk(halted == 0, "R11 halted", halted, 0);
        m_pc = 0; m_acc = 0; m_halt = 0;
        release_reset();
        run_prog(10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule